// File: doc/BRIEF.md
# Hart Privilege and Trap-Return Unit

This block holds the current privilege level of one 32-bit hart, the interrupt-enable stack of the machine status register, and the two saved exception PCs (machine and supervisor). A trap request moves the hart into machine mode and saves the interrupted context. The machine-return and supervisor-return strobes pop that context back and give a redirect target. A small CSR port lets software read and write the status register and both saved PCs.

Software running in machine mode can load the previous-privilege and previous-enable fields before it issues a machine return. The hart then lands in supervisor or user mode with the interrupt-enable value that software chose. This is how a boot stage hands control to a kernel. Decode, delegation, translation, memory protection and interrupt selection all stay outside the block.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset the privilege is machine (2'b11), the status register reads 0, and both saved PCs read 0.
- R2: Privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11. The CSR addresses are status 12'h300, machine EPC 12'h341 and supervisor EPC 12'h141. Any other address reads 0.
- R3: The status register fields are UIE bit 0, SIE bit 1, MIE bit 3, UPIE bit 4, SPIE bit 5, MPIE bit 7, SPP bit 8 and MPP bits 12:11. Every other bit reads 0 whatever is written.
- R4: A trap sets the privilege to machine on the next edge. MEPC becomes trap_pc with bit 0 cleared, MPP takes the old privilege, MPIE takes the old MIE, and MIE becomes 0.
- R5: In a trap cycle, redir_valid is 1 and redir_pc equals trap_vec in that same cycle.
- R6: A return from machine mode that is issued in machine mode sets the privilege to MPP, MIE to MPIE, MPIE to 1 and MPP to 00. In the same cycle it drives redir_valid with redir_pc equal to MEPC.
- R7: A machine return issued below machine mode raises illegal in that cycle. It changes no state and gives no redirect.
- R8: A supervisor return issued in supervisor or machine mode sets the privilege to SPP (0 gives user, 1 gives supervisor), SIE to SPIE, SPIE to 1 and SPP to 0. In the same cycle it redirects to SEPC.
- R9: A supervisor return issued in user mode raises illegal in that cycle. It changes no state and gives no redirect.
- R10: A write of 2'b10 to MPP keeps the previous MPP. The other status fields are still written in that cycle.
- R11: Bit 0 of both saved PCs always reads 0.
- R12: A trap wins over a return strobe and over a CSR write in the same cycle, and the redirect is trap_vec. A CSR write in the same cycle as either return strobe is dropped. If both return strobes are present, only the machine return is considered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap into machine mode |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_vec | input | 32 | Trap handler address |
| mret | input | 1 | Machine-return strobe |
| sret | input | 1 | Supervisor-return strobe |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| priv | output | 2 | Current privilege level |
| redir_valid | output | 1 | Redirect the fetch this cycle |
| redir_pc | output | 32 | Redirect target |
| illegal | output | 1 | Return strobe not allowed at the current privilege |
| mstatus | output | 32 | Current status register value |

## Verification
Two pairs of events can land in the same cycle: a trap together with a CSR write to MEPC, and a machine return together with a CSR write to the status register. The bench drives each pair in one cycle. It then reads back MEPC and checks that it holds the trap PC. It reads back the status register and checks that it holds the popped value, not the written word. A trap raised together with a machine return is judged by redir_pc, which must equal trap_vec, and by the new MPP, which must equal the old privilege.

// File: rtl/priv_trap_unit.sv
module priv_trap_unit #(
  parameter int          XLEN      = 32,
  parameter logic [11:0] A_MSTATUS = 12'h300,
  parameter logic [11:0] A_MEPC    = 12'h341,
  parameter logic [11:0] A_SEPC    = 12'h141
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_vec,
  input  logic            mret,
  input  logic            sret,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic [1:0]      priv,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            illegal,
  output logic [XLEN-1:0] mstatus
);
  localparam logic [1:0] LVL_U = 2'b00;
  localparam logic [1:0] LVL_M = 2'b11;

  logic [1:0]      lvl, mpp;
  logic            uie, sie, mie, upie, spie, mpie, spp;
  logic [XLEN-1:0] mepc, sepc;

  wire m_ok    = mret & (lvl == LVL_M);
  wire s_ok    = sret & (lvl != LVL_U);
  wire do_mret = ~trap_req & m_ok;
  wire do_sret = ~trap_req & ~mret & s_ok;
  wire do_wr   = csr_we & ~trap_req & ~mret & ~sret;

  assign illegal     = mret ? ~m_ok : (sret & ~s_ok);
  assign redir_valid = trap_req | do_mret | do_sret;
  assign redir_pc    = trap_req ? trap_vec : do_mret ? mepc : do_sret ? sepc : '0;
  assign priv        = lvl;
  assign mstatus     = {{(XLEN-13){1'b0}}, mpp, 2'b00, spp, mpie, 1'b0,
                        spie, upie, mie, 1'b0, sie, uie};

  always_comb begin
    if (csr_addr == A_MSTATUS)   csr_rdata = mstatus;
    else if (csr_addr == A_MEPC) csr_rdata = mepc;
    else if (csr_addr == A_SEPC) csr_rdata = sepc;
    else                         csr_rdata = '0;
  end

  logic unused_bits;
  assign unused_bits = ^{trap_pc[0], csr_wdata[XLEN-1:13], csr_wdata[10:9],
                         csr_wdata[6], csr_wdata[2], csr_wdata[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= LVL_M; mpp <= LVL_U;
      {uie, sie, mie, upie, spie, mpie, spp} <= '0;
      mepc <= '0; sepc <= '0;
    end else if (trap_req) begin
      mepc <= {trap_pc[XLEN-1:1], 1'b0};
      mpp  <= lvl;
      mpie <= mie;
      mie  <= 1'b0;
      lvl  <= LVL_M;
    end else if (do_mret) begin
      lvl  <= mpp;
      mie  <= mpie;
      mpie <= 1'b1;
      mpp  <= LVL_U;
    end else if (do_sret) begin
      lvl  <= {1'b0, spp};
      sie  <= spie;
      spie <= 1'b1;
      spp  <= 1'b0;
    end else if (do_wr) begin
      if (csr_addr == A_MSTATUS) begin
        uie  <= csr_wdata[0];
        sie  <= csr_wdata[1];
        mie  <= csr_wdata[3];
        upie <= csr_wdata[4];
        spie <= csr_wdata[5];
        mpie <= csr_wdata[7];
        spp  <= csr_wdata[8];
        if (csr_wdata[12:11] != 2'b10) mpp <= csr_wdata[12:11];
      end else if (csr_addr == A_MEPC) begin
        mepc <= {csr_wdata[XLEN-1:1], 1'b0};
      end else if (csr_addr == A_SEPC) begin
        sepc <= {csr_wdata[XLEN-1:1], 1'b0};
      end
    end
  end

  a_r4_trap_entry: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (lvl == LVL_M) && !mie && (mpie == $past(mie)) && (mpp == $past(lvl)));

  a_r6_mret_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !trap_req && lvl == LVL_M) |=>
      (lvl == $past(mpp)) && (mie == $past(mpie)) && mpie && (mpp == LVL_U));

  a_r7_mret_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !trap_req && lvl != LVL_M) |=>
      (lvl == $past(lvl)) && (mstatus == $past(mstatus)) && (mepc == $past(mepc)));

  a_r8_sret_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (sret && !mret && !trap_req && lvl != LVL_U) |=>
      (lvl == {1'b0, $past(spp)}) && (sie == $past(spie)) && spie && !spp);

  a_r9_sret_user: assert property (@(posedge clk) disable iff (!rst_n)
    (sret && !mret && lvl == LVL_U) |-> illegal && !(redir_valid && !trap_req));

  a_r10_mpp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mpp != 2'b10);

  a_r12_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && csr_we) |=> mepc == {$past(trap_pc[XLEN-1:1]), 1'b0});
endmodule

// File: tb/sim_priv_trap_unit.sv
module sim_priv_trap_unit;
  localparam int PER = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        trap_req = 0, mret = 0, sret = 0, csr_we = 0;
  logic [31:0] trap_pc = 0, trap_vec = 32'h0000_0100, csr_wdata = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_rdata, redir_pc, mstatus;
  logic [1:0]  priv;
  logic        redir_valid, illegal;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [11:0] AS = 12'h300, AM = 12'h341, AE = 12'h141;

  always #(PER/2) clk = ~clk;

  priv_trap_unit u0 (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_pc(trap_pc),
    .trap_vec(trap_vec), .mret(mret), .sret(sret), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .priv(priv), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .illegal(illegal), .mstatus(mstatus));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(PER*200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ms, pc;
    logic [1:0]  cur_mpp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 priv", {30'd0, priv}, 32'd3);
    chk("R1 redir", {31'd0, redir_valid}, 0);
    rd(AS, d); chk("R1 mstatus", d, 0);
    rd(AM, d); chk("R1 mepc", d, 0);
    rd(AE, d); chk("R1 sepc", d, 0);
    @(negedge clk);

    cur_mpp = 2'b00;
    for (int v = 0; v < 8192; v++) begin
      wr(AS, v | 32'hFFFF_E000);
      ms = v & 32'h19BB;
      if (v[12:11] == 2'b10) ms = (ms & ~32'h1800) | ({30'd0, cur_mpp} << 11);
      else cur_mpp = v[12:11];
      rd(AS, d); chk("R3 R10 mstatus write", d, ms);
    end

    for (int k = 0; k < 4; k++) begin
      pc = 32'h8000_0001 + 32'h1234_5677 * k;
      wr(AM, pc); wr(AE, ~pc);
      rd(AM, d); chk("R11 mepc bit0", d, pc & ~32'd1);
      rd(AE, d); chk("R11 sepc bit0", d, ~pc & ~32'd1);
      rd(12'h342, d); chk("R2 unmapped", d, 0);
      @(negedge clk);
    end

    for (int p = 0; p < 4; p++) begin
      if (p == 2) continue;
      for (int pi = 0; pi < 2; pi++)
        for (int mi = 0; mi < 2; mi++) begin
          wr(AS, (p << 11) | (pi << 7) | (mi << 3));
          pc = 32'h8000_4001 + (p << 8) + (pi << 4);
          wr(AM, pc);
          mret = 1; #1;
          chk("R6 redir_valid", {31'd0, redir_valid}, 1);
          chk("R6 redir_pc", redir_pc, pc & ~32'd1);
          chk("R6 illegal", {31'd0, illegal}, 0);
          @(negedge clk); mret = 0; #1;
          chk("R6 R2 priv", {30'd0, priv}, p);
          rd(AS, d); chk("R6 mstatus", d, (pi << 3) | 32'h80);
          @(negedge clk);
          if (p != 3) begin
            mret = 1; #1;
            chk("R7 illegal", {31'd0, illegal}, 1);
            chk("R7 redir", {31'd0, redir_valid}, 0);
            @(negedge clk); mret = 0; #1;
            chk("R7 priv kept", {30'd0, priv}, p);
            rd(AS, d); chk("R7 mstatus kept", d, (pi << 3) | 32'h80);
            rd(AM, d); chk("R7 mepc kept", d, pc & ~32'd1);
            @(negedge clk);
          end
          if (p == 0) begin
            sret = 1; #1;
            chk("R9 illegal", {31'd0, illegal}, 1);
            chk("R9 redir", {31'd0, redir_valid}, 0);
            @(negedge clk); sret = 0; #1;
            chk("R9 priv kept", {30'd0, priv}, 0);
            rd(AS, d); chk("R9 mstatus kept", d, (pi << 3) | 32'h80);
            @(negedge clk);
          end
          trap_req = 1; trap_pc = 32'h0000_2003 + (p << 4); trap_vec = 32'h0000_0100 + (mi << 6); #1;
          chk("R5 redir_valid", {31'd0, redir_valid}, 1);
          chk("R5 redir_pc", redir_pc, trap_vec);
          @(negedge clk); trap_req = 0; #1;
          chk("R4 priv", {30'd0, priv}, 3);
          rd(AS, d); chk("R4 mstatus", d, (p << 11) | (pi << 7));
          rd(AM, d); chk("R4 mepc", d, trap_pc & ~32'd1);
          @(negedge clk);
        end
    end

    for (int sp = 0; sp < 2; sp++)
      for (int spi = 0; spi < 2; spi++)
        for (int si = 0; si < 2; si++) begin
          wr(AS, (sp << 8) | (spi << 5) | (si << 1));
          pc = 32'hC000_0011 + (sp << 12) + (spi << 8);
          wr(AE, pc);
          sret = 1; #1;
          chk("R8 redir_valid", {31'd0, redir_valid}, 1);
          chk("R8 redir_pc", redir_pc, pc & ~32'd1);
          chk("R8 illegal", {31'd0, illegal}, 0);
          @(negedge clk); sret = 0; #1;
          chk("R8 priv", {30'd0, priv}, sp);
          rd(AS, d); chk("R8 mstatus", d, (spi << 1) | 32'h20);
          @(negedge clk);
          if (sp == 1) begin
            sret = 1; #1;
            chk("R8 from S legal", {31'd0, redir_valid}, 1);
            @(negedge clk); sret = 0; #1;
            chk("R8 S to U", {30'd0, priv}, 0);
            @(negedge clk);
          end
          trap_req = 1; trap_pc = 32'h0000_3000;
          @(negedge clk); trap_req = 0; #1;
          chk("R4 back to M", {30'd0, priv}, 3);
          @(negedge clk);
        end

    trap_req = 1; trap_pc = 32'h0000_5555; trap_vec = 32'h0000_0200;
    csr_we = 1; csr_addr = AM; csr_wdata = 32'h1111_1110;
    @(negedge clk); trap_req = 0; csr_we = 0;
    rd(AM, d); chk("R12 trap over write", d, 32'h0000_5554);
    @(negedge clk);

    wr(AS, 32'h0000_0800);
    trap_req = 1; mret = 1; trap_pc = 32'h0000_6000; #1;
    chk("R12 trap over mret pc", redir_pc, 32'h0000_0200);
    @(negedge clk); trap_req = 0; mret = 0; #1;
    chk("R12 priv", {30'd0, priv}, 3);
    rd(AS, d); chk("R12 mpp from trap", d, 32'h1800);
    @(negedge clk);

    wr(AS, 32'h0000_0800);
    mret = 1; csr_we = 1; csr_addr = AS; csr_wdata = 32'h0000_1888;
    @(negedge clk); mret = 0; csr_we = 0; #1;
    chk("R12 mret priv", {30'd0, priv}, 1);
    rd(AS, d); chk("R12 write dropped", d, 32'h80);
    @(negedge clk);

    mret = 1; sret = 1; #1;
    chk("R12 both strobes illegal", {31'd0, illegal}, 1);
    chk("R12 both strobes redir", {31'd0, redir_valid}, 0);
    @(negedge clk); mret = 0; sret = 0; #1;
    chk("R12 both strobes priv", {30'd0, priv}, 1);
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule